// File: doc/BRIEF.md
# Byte Serializer and Deserializer with Loopback Paths

This block is the serial datapath of a byte-wide line interface, modelled entirely in one fast bit-clock domain. A free-running three-bit counter divides the bit clock by eight and produces a one-cycle byte strobe. On every strobe the transmit side captures a parallel word into a holding register. When the byte currently on the line has fully shifted out, the held word is loaded into a shift register and sent most significant bit first, one bit per clock. The receive side shifts in one serial bit per clock. At each byte boundary it presents the assembled byte together with the strobe.

Two loopback controls reroute the serial streams through a small registered selector state machine with four states: `LB_DIRECT`, `LB_FACILITY`, `LB_EQUIPMENT` and `LB_CONFLICT`. Every cycle the next state is decoded from the two control inputs:
- no request leads to `LB_DIRECT`;
- the facility request alone leads to `LB_FACILITY`;
- the equipment request alone leads to `LB_EQUIPMENT`;
- both requests lead to `LB_CONFLICT`.

Any state can therefore move to any other in a single cycle, and synchronous reset forces `LB_DIRECT`. In facility loopback the received line bit is driven straight onto the transmit output, and it is still deserialized. In equipment loopback the transmit shifter output replaces the line input of the deserializer, and it is still driven onto the transmit output. `LB_CONFLICT` behaves like facility loopback and also raises an error flag.

Top module: `serlb_serdes`

## Requirements
- R1: `byte_strobe` is high for exactly one cycle in every eight. The first pulse comes eight cycles after synchronous reset is released.
- R2: The word on `tx_word` in a cycle where `byte_strobe` is high appears on `tx_ser` most significant bit first, one bit per cycle, in the 8th through 15th cycles after that strobe cycle. This holds when facility loopback is not selected.
- R3: With no loopback, the `rx_ser` bits of the eight cycles starting with a strobe cycle form one byte, the first bit being the most significant. That byte appears on `rx_byte` in the next strobe cycle and is held until the strobe after that.
- R4: While facility loopback is selected, `tx_ser` equals `rx_ser` in the same cycle.
- R5: While facility loopback is selected, `rx_ser` is still deserialized onto `rx_byte` exactly as in R3.
- R6: While equipment loopback is selected, `rx_ser` is ignored and the deserializer takes the transmit stream. A word presented in a strobe cycle then appears on `rx_byte` 16 cycles later.
- R7: While equipment loopback is selected, the transmit stream still appears on `tx_ser` exactly as in R2.
- R8: When `fac_loop` and `equ_loop` are both high, facility loopback is used and `loop_err` is high from the next cycle on.
- R9: A change on the loopback controls takes effect on the data paths one cycle later.
- R10: Synchronous reset clears the shift registers, the holding register, the bit counter, the strobe and the selector. While reset is held, `tx_ser`, `rx_byte`, `byte_strobe` and `loop_err` are all 0.
- R11: `loop_err` is low in every cycle that follows a cycle in which the two loopback controls were not both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_word | input | 8 | Parallel transmit word, sampled when `byte_strobe` is high |
| rx_ser | input | 1 | Serial receive bit from the line |
| fac_loop | input | 1 | Facility loopback request |
| equ_loop | input | 1 | Equipment loopback request |
| tx_ser | output | 1 | Serial transmit bit to the line |
| rx_byte | output | 8 | Deserialized receive byte |
| byte_strobe | output | 1 | Byte-rate strobe, bit clock divided by eight |
| loop_err | output | 1 | Both loopbacks requested |

## Verification
Each vector is timed from the cycle in which `byte_strobe` is seen high, called cycle k:
- the transmit bits are due in cycles k+8 to k+15;
- the byte received directly or through facility loopback is due with the strobe at k+8;
- the byte that returns through equipment loopback is due at k+16;
- a facility-looped bit is due in the same cycle it is driven;
- selector changes and `loop_err` are due one cycle after the controls change.

The bench samples every output on the falling edge before it drives new inputs, so each expected value is compared at its exact cycle offset. The first strobe after reset is counted at exactly eight cycles.

// File: rtl/serlb_pkg.sv
package serlb_pkg;
    typedef enum logic [1:0] {
        LB_DIRECT    = 2'd0,
        LB_FACILITY  = 2'd1,
        LB_EQUIPMENT = 2'd2,
        LB_CONFLICT  = 2'd3
    } lb_state_e;
endpackage

// File: rtl/serlb_bit_timer.sv
module serlb_bit_timer #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst,
    output logic last_bit,
    output logic byte_strobe
);
    localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [CW-1:0] bit_cnt;

    assign last_bit = (bit_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt     <= '0;
            byte_strobe <= 1'b0;
        end else begin
            bit_cnt     <= last_bit ? '0 : bit_cnt + 1'b1;
            byte_strobe <= last_bit;
        end
    end

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        byte_strobe |=> !byte_strobe);
endmodule

// File: rtl/serlb_tx_shift.sv
module serlb_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_strobe,
    input  logic              last_bit,
    input  logic [BYTE_W-1:0] tx_word,
    output logic              tx_bit
);
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shift_q <= '0;
        end else begin
            if (byte_strobe)
                hold_q <= tx_word;
            if (last_bit)
                shift_q <= hold_q;
            else
                shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign tx_bit = shift_q[BYTE_W-1];
endmodule

// File: rtl/serlb_rx_shift.sv
module serlb_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              last_bit,
    input  logic              ser_in,
    output logic [BYTE_W-1:0] rx_byte
);
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_d;

    assign shift_d = {shift_q[BYTE_W-2:0], ser_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            rx_byte <= '0;
        end else begin
            shift_q <= shift_d;
            if (last_bit)
                rx_byte <= shift_d;
        end
    end
endmodule

// File: rtl/serlb_loop_ctrl.sv
module serlb_loop_ctrl
    import serlb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fac_req,
    input  logic equ_req,
    output logic sel_fac,
    output logic sel_equ,
    output logic loop_err
);
    lb_state_e state_q, state_d;

    always_comb begin
        unique case ({fac_req, equ_req})
            2'b00:   state_d = LB_DIRECT;
            2'b10:   state_d = LB_FACILITY;
            2'b01:   state_d = LB_EQUIPMENT;
            default: state_d = LB_CONFLICT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= LB_DIRECT;
        else
            state_q <= state_d;
    end

    always_comb begin
        sel_fac  = 1'b0;
        sel_equ  = 1'b0;
        loop_err = 1'b0;
        unique case (state_q)
            LB_DIRECT:    ;
            LB_FACILITY:  sel_fac = 1'b1;
            LB_EQUIPMENT: sel_equ = 1'b1;
            LB_CONFLICT: begin
                sel_fac  = 1'b1;
                loop_err = 1'b1;
            end
            default:      ;
        endcase
    end

    // R8
    both_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (fac_req && equ_req) |=> (loop_err && sel_fac && !sel_equ));

    // R11
    no_false_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !(fac_req && equ_req) |=> !loop_err);
endmodule

// File: rtl/serlb_serdes.sv
module serlb_serdes #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] tx_word,
    input  logic              rx_ser,
    input  logic              fac_loop,
    input  logic              equ_loop,
    output logic              tx_ser,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_strobe,
    output logic              loop_err
);
    logic last_bit;
    logic tx_bit;
    logic sel_fac;
    logic sel_equ;
    logic deser_in;

    serlb_bit_timer #(.BYTE_W(BYTE_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .last_bit    (last_bit),
        .byte_strobe (byte_strobe)
    );

    serlb_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .byte_strobe (byte_strobe),
        .last_bit    (last_bit),
        .tx_word     (tx_word),
        .tx_bit      (tx_bit)
    );

    serlb_loop_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fac_req  (fac_loop),
        .equ_req  (equ_loop),
        .sel_fac  (sel_fac),
        .sel_equ  (sel_equ),
        .loop_err (loop_err)
    );

    assign tx_ser   = sel_fac ? rx_ser : tx_bit;
    assign deser_in = sel_equ ? tx_bit : rx_ser;

    serlb_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .last_bit (last_bit),
        .ser_in   (deser_in),
        .rx_byte  (rx_byte)
    );

    // R4 and R9
    fac_follow_chk: assert property (@(posedge clk) disable iff (rst)
        fac_loop |=> (tx_ser == rx_ser));

    // R7
    equ_still_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (equ_loop && !fac_loop) |=> (tx_ser == tx_bit));
endmodule

// File: tb/tb_serlb_serdes.sv
module tb_serlb_serdes;
    localparam int PERIOD = 10;
    localparam int W      = 8;
    localparam int NVEC   = 8;

    // {fac, equ, tx word, rx pattern}
    localparam logic [17:0] VEC [NVEC] = '{
        {2'b00, 8'hA5, 8'h3C},
        {2'b00, 8'h80, 8'h01},
        {2'b10, 8'h00, 8'hC9},
        {2'b10, 8'hFF, 8'h6E},
        {2'b01, 8'h5B, 8'hFF},
        {2'b01, 8'h81, 8'h00},
        {2'b11, 8'h33, 8'hD2},
        {2'b00, 8'hFF, 8'h00}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] tx_word;
    logic         rx_ser;
    logic         fac_loop;
    logic         equ_loop;
    logic         tx_ser;
    logic [W-1:0] rx_byte;
    logic         byte_strobe;
    logic         loop_err;

    int nchk  = 0;
    int nfail = 0;

    serlb_serdes #(.BYTE_W(W)) dut (
        .clk         (clk),
        .rst         (rst),
        .tx_word     (tx_word),
        .rx_ser      (rx_ser),
        .fac_loop    (fac_loop),
        .equ_loop    (equ_loop),
        .tx_ser      (tx_ser),
        .rx_byte     (rx_byte),
        .byte_strobe (byte_strobe),
        .loop_err    (loop_err)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic       fac, equ, lastd;
        logic [7:0] txw, pat;
        int         n;

        rst = 1'b1; tx_word = '0; rx_ser = 1'b0; fac_loop = 1'b0; equ_loop = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 tx_ser", 8'(tx_ser), 8'h0);
        chk("R10 rx_byte", rx_byte, 8'h00);
        chk("R10 strobe", 8'(byte_strobe), 8'h0);
        chk("R10 loop_err", 8'(loop_err), 8'h0);

        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!byte_strobe && n < 20);
        // R1 first strobe eight cycles after release
        chk("R1 first strobe distance", 8'(n), 8'd8);

        for (int v = 0; v < NVEC; v++) begin
            {fac, equ, txw, pat} = VEC[v];
            fac_loop = fac; equ_loop = equ; tx_word = txw;
            @(negedge clk);
            n = 0;
            while (!byte_strobe && n < 20) begin
                @(negedge clk);
                n++;
            end
            lastd = rx_ser;
            // R8 and R11 flag state
            chk(fac && equ ? "R8 loop_err" : "R11 loop_err", 8'(loop_err), 8'(fac && equ));
            for (int i = 0; i <= 16; i++) begin
                if (i > 0)
                    chk("R1 strobe spacing", 8'(byte_strobe), 8'(i == 8 || i == 16));
                if (fac) begin
                    if (i > 0) chk(equ ? "R8 tx path" : "R4 tx follows rx", 8'(tx_ser), 8'(lastd));
                end else if (i >= 8 && i <= 15) begin
                    chk(equ ? "R7 tx during equipment" : "R2 tx msb first", 8'(tx_ser), 8'(txw[15-i]));
                end
                if (i == 8 && !(equ && !fac))
                    chk(fac ? "R5 rx in facility" : "R3 rx byte", rx_byte, pat);
                if (i == 16)
                    chk((equ && !fac) ? "R6 equipment return" : "R3 rx zero byte",
                        rx_byte, (equ && !fac) ? txw : 8'h00);
                rx_ser = (i < 8) ? pat[7-i] : 1'b0;
                lastd  = rx_ser;
                @(negedge clk);
            end
        end

        // R9 loopback control takes effect one cycle later
        rst = 1'b1; fac_loop = 1'b0; equ_loop = 1'b0; tx_word = 8'h00; rx_ser = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        fac_loop = 1'b1; rx_ser = 1'b1;
        #1;
        chk("R9 not yet looped", 8'(tx_ser), 8'h0);
        @(negedge clk);
        chk("R9 looped next cycle", 8'(tx_ser), 8'h1);

        // R10 reset in the middle of activity
        equ_loop = 1'b1; tx_word = 8'hFF;
        repeat (20) @(negedge clk);
        chk("R8 flag before reset", 8'(loop_err), 8'h1);
        rst = 1'b1; fac_loop = 1'b0; equ_loop = 1'b0;
        @(negedge clk);
        chk("R10 mid tx_ser", 8'(tx_ser), 8'h0);
        chk("R10 mid rx_byte", rx_byte, 8'h00);
        chk("R10 mid strobe", 8'(byte_strobe), 8'h0);
        chk("R10 mid loop_err", 8'(loop_err), 8'h0);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!byte_strobe && n < 20);
        chk("R1 strobe after mid reset", 8'(n), 8'd8);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule